// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services a translation miss in hardware. Given a 32-bit faulting virtual address and the base of a page directory, it performs two dependent memory lookups: one into the directory to find the base of a page table, and one into that table to fetch a pair of adjacent page entries (even and odd). Each entry word is shifted right by a software-chosen amount before it is returned, so that bits used only by system software fall off the bottom. A zero directory base means no table is known. In that case the walk ends at once with a no-match result, so that a software handler can take over.

The walker uses a simple read port that carries one read at a time. It raises a request with an address and holds both until the memory answers with a response-valid strobe and the data. A single start pulse launches a walk. A single done pulse ends it, and the no-match flag and the two entry words are valid alongside that pulse.

Top module: `ptw_walker`

## Requirements
- R1: A start with a zero directory base raises done_o and nomatch_o together one cycle after start is sampled. No read request is raised, and both entry outputs read zero.
- R2: The first read of a walk targets (dir_base_i & 0x1FFF_FFFF) + vaddr_i[31:22] * 4.
- R3: The second read targets (D & 0x1FFF_FFFF) + vaddr_i[21:13] * 8, where D is the word returned by the first read.
- R4: The third read targets the second read's address plus 4. A walk with a nonzero base makes exactly three reads.
- R5: entry_even_o is the second read's data shifted right by soft_shift_i, and entry_odd_o is the third read's data shifted the same way. The shift amount is the value sampled with start; later changes to the input have no effect on the walk.
- R6: Once raised, rd_req_o stays high with a constant rd_addr_o until rd_valid_i is sampled high. An rd_valid_i strobe while no request is pending is ignored.
- R7: busy_o is high from the cycle after start through the done cycle. A start pulse while busy_o is high is ignored and does not alter the walk's result.
- R8: done_o is a one-cycle pulse, and nomatch_o is low on a walk with a nonzero base. The entry outputs hold their values after done until the next accepted start.
- R9: After reset, busy_o, done_o, nomatch_o and rd_req_o are low and both entry outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a walk (sampled only while idle) |
| dir_base_i | input | 32 | Page directory base address, zero when unknown |
| vaddr_i | input | 32 | Faulting virtual address |
| soft_shift_i | input | 5 | Right-shift applied to each returned entry |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| nomatch_o | output | 1 | With done_o: no directory was available |
| entry_even_o | output | 32 | Shifted even page entry |
| entry_odd_o | output | 32 | Shifted odd page entry |
| rd_req_o | output | 1 | Read request pending |
| rd_addr_o | output | 32 | Read byte address |
| rd_valid_i | input | 1 | Read response strobe |
| rd_data_i | input | 32 | Read response data |

## Verification
The assertions check on every cycle that a pending request holds its address until answered, that done is a single-cycle pulse covered by busy, and that a zero-base walk finishes with no read. They also check that the captured shift stays fixed through a walk and that every successful walk counts exactly three accepted reads. The bench's scenarios cover the rest. It checks the actual address arithmetic against a modelled memory and the shifted entry values under random bases, addresses, shifts and response latencies. It also checks that a stray response strobe while idle and a second start while busy leave the results unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_EVEN,
    ST_ODD,
    ST_FIN
  } walk_state_t;
endpackage

// File: rtl/ptw_addr_gen.sv
// Address arithmetic for both walk levels.
module ptw_addr_gen #(
  parameter int AW           = 32,
  parameter int PHYS_BITS    = 29,
  parameter int DIR_LSB      = 22,
  parameter int PT_LSB       = 13,
  parameter int PT_BITS      = 9,
  parameter int DIR_ENT_LOG  = 2,
  parameter int PAIR_LOG     = 3
) (
  input  logic [AW-1:0] dir_base_i,
  input  logic [AW-1:0] vaddr_new_i,
  input  logic [AW-1:0] pt_word_i,
  input  logic [AW-1:0] vaddr_held_i,
  output logic [AW-1:0] dir_addr_o,
  output logic [AW-1:0] pair_addr_o
);
  localparam int DIR_BITS = AW - DIR_LSB;
  localparam logic [AW-1:0] PHYS_MASK = AW'((64'd1 << PHYS_BITS) - 64'd1);

  logic [DIR_BITS-1:0] dir_idx;
  logic [PT_BITS-1:0]  pt_idx;
  logic [AW-1:0]       dir_off, pair_off;

  assign dir_idx  = vaddr_new_i[AW-1:DIR_LSB];
  assign pt_idx   = vaddr_held_i[PT_LSB +: PT_BITS];
  assign dir_off  = {{(AW-DIR_BITS){1'b0}}, dir_idx} << DIR_ENT_LOG;
  assign pair_off = {{(AW-PT_BITS){1'b0}}, pt_idx} << PAIR_LOG;

  assign dir_addr_o  = (dir_base_i & PHYS_MASK) + dir_off;
  assign pair_addr_o = (pt_word_i & PHYS_MASK) + pair_off;
endmodule

// File: rtl/ptw_soft_shift.sv
// Logarithmic right shifter, one stage per amount bit.
module ptw_soft_shift #(
  parameter int DW = 32,
  parameter int SW = 5
) (
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] amt_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] stage [SW+1];

  assign stage[0] = data_i;
  for (genvar g = 0; g < SW; g++) begin : g_stage
    assign stage[g+1] = amt_i[g] ? (stage[g] >> (2**g)) : stage[g];
  end
  assign data_o = stage[SW];
endmodule

// File: rtl/ptw_ctrl.sv
// Walk sequencer: idle -> directory -> even -> odd -> finish.
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        base_zero_i,
  input  logic        rd_valid_i,
  output walk_state_t state_o,
  output logic        launch_o,
  output logic        accept_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        req_o
);
  walk_state_t state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = base_zero_i ? ST_FIN : ST_DIR;
      ST_DIR:  if (rd_valid_i) state_d = ST_EVEN;
      ST_EVEN: if (rd_valid_i) state_d = ST_ODD;
      ST_ODD:  if (rd_valid_i) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_o  = state_q;
  assign launch_o = (state_q == ST_IDLE) && start_i;
  assign req_o    = (state_q == ST_DIR) || (state_q == ST_EVEN) || (state_q == ST_ODD);
  assign accept_o = req_o && rd_valid_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);

  // R1: zero base ends on the next cycle without a request
  a_r1_zero_base_fast: assert property (@(posedge clk) disable iff (rst)
    (launch_o && base_zero_i) |=> (done_o && !req_o));

  // R6: an unanswered request stays raised
  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    (req_o && !rd_valid_i) |=> req_o);

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: busy covers the done cycle and a start while busy launches nothing
  a_r7_busy_at_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o);
  a_r7_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/ptw_walker.sv
// Two-level page table walker top.
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int PHYS_BITS = 29,
  parameter int DIR_LSB   = 22,
  parameter int PT_LSB    = 13,
  parameter int PT_BITS   = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [AW-1:0]         dir_base_i,
  input  logic [AW-1:0]         vaddr_i,
  input  logic [$clog2(DW)-1:0] soft_shift_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  nomatch_o,
  output logic [DW-1:0]         entry_even_o,
  output logic [DW-1:0]         entry_odd_o,
  output logic                  rd_req_o,
  output logic [AW-1:0]         rd_addr_o,
  input  logic                  rd_valid_i,
  input  logic [DW-1:0]         rd_data_i
);
  localparam int SW        = $clog2(DW);
  localparam int WORD_B    = DW / 8;
  localparam int WORD_LOG  = $clog2(WORD_B);

  walk_state_t   state;
  logic          launch, accept, base_zero;
  logic [AW-1:0] vaddr_q, addr_q, dir_addr, pair_addr;
  logic [SW-1:0] shift_q;
  logic [DW-1:0] even_q, odd_q, shifted;
  logic          nomatch_q;
  logic [1:0]    rd_cnt_q;

  assign base_zero = (dir_base_i == '0);

  ptw_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .base_zero_i(base_zero),
    .rd_valid_i (rd_valid_i),
    .state_o    (state),
    .launch_o   (launch),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .req_o      (rd_req_o)
  );

  ptw_addr_gen #(
    .AW(AW), .PHYS_BITS(PHYS_BITS), .DIR_LSB(DIR_LSB), .PT_LSB(PT_LSB),
    .PT_BITS(PT_BITS), .DIR_ENT_LOG(WORD_LOG), .PAIR_LOG(WORD_LOG + 1)
  ) u_addr (
    .dir_base_i  (dir_base_i),
    .vaddr_new_i (vaddr_i),
    .pt_word_i   (AW'(rd_data_i)),
    .vaddr_held_i(vaddr_q),
    .dir_addr_o  (dir_addr),
    .pair_addr_o (pair_addr)
  );

  ptw_soft_shift #(.DW(DW), .SW(SW)) u_shift (
    .data_i(rd_data_i),
    .amt_i (shift_q),
    .data_o(shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vaddr_q   <= '0;
      shift_q   <= '0;
      addr_q    <= '0;
      even_q    <= '0;
      odd_q     <= '0;
      nomatch_q <= 1'b0;
    end else if (launch) begin
      vaddr_q   <= vaddr_i;
      shift_q   <= soft_shift_i;
      addr_q    <= dir_addr;
      even_q    <= '0;
      odd_q     <= '0;
      nomatch_q <= base_zero;
    end else if (accept) begin
      unique case (state)
        ST_DIR:  addr_q <= pair_addr;
        ST_EVEN: begin
          even_q <= shifted;
          addr_q <= addr_q + AW'(WORD_B);
        end
        ST_ODD:  odd_q <= shifted;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_cnt_q <= '0;
    else if (launch) rd_cnt_q <= '0;
    else if (accept) rd_cnt_q <= rd_cnt_q + 2'd1;
  end

  assign rd_addr_o    = addr_q;
  assign nomatch_o    = done_o && nomatch_q;
  assign entry_even_o = even_q;
  assign entry_odd_o  = odd_q;

  // R6: address stays put while a request waits
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i) |=> $stable(rd_addr_o));

  // R5: captured shift is frozen for the whole walk
  a_r5_shift_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> $stable(shift_q));

  // R4: a successful walk accepted exactly three reads
  a_r4_three_reads: assert property (@(posedge clk) disable iff (rst)
    (done_o && !nomatch_o) |-> (rd_cnt_q == 2'd3));

  // R1: a no-match walk accepted no read and returns zero entries
  a_r1_no_reads: assert property (@(posedge clk) disable iff (rst)
    nomatch_o |-> (rd_cnt_q == 2'd0 && entry_even_o == '0 && entry_odd_o == '0));

  // R8: entries hold while idle
  a_r8_entries_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(entry_even_o) && $stable(entry_odd_o)));
endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [31:0] dir_base_i, vaddr_i;
  logic [4:0]  soft_shift_i;
  logic        busy_o, done_o, nomatch_o, rd_req_o;
  logic [31:0] entry_even_o, entry_odd_o, rd_addr_o;
  logic        rd_valid_i;
  logic [31:0] rd_data_i;

  int checks = 0;
  int errors = 0;
  int nlog = 0;
  logic [31:0] addr_log [8];
  int lat_max = 0;
  int wait_cnt = 0;
  bit stray = 1'b0;

  always #2.5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_base_i(dir_base_i),
    .vaddr_i(vaddr_i), .soft_shift_i(soft_shift_i), .busy_o(busy_o),
    .done_o(done_o), .nomatch_o(nomatch_o), .entry_even_o(entry_even_o),
    .entry_odd_o(entry_odd_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    h = (a ^ (a >> 15)) * 32'h2C1B_3C6D;
    return h ^ (h >> 13) ^ 32'h297A_2D39;
  endfunction

  function automatic logic [31:0] exp_dir(input logic [31:0] b, input logic [31:0] va);
    return (b & 32'h1FFF_FFFF) + ({22'd0, va[31:22]} << 2);
  endfunction

  function automatic logic [31:0] exp_pair(input logic [31:0] d, input logic [31:0] va);
    return (d & 32'h1FFF_FFFF) + ({23'd0, va[21:13]} << 3);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    rd_valid_i = 1'b0;
    rd_data_i  = '0;
    forever begin
      @(negedge clk);
      rd_valid_i = 1'b0;
      if (stray) begin
        rd_valid_i = 1'b1;
        rd_data_i  = 32'hDEAD_BEEF;
      end else if (rd_req_o) begin
        if (wait_cnt == 0) begin
          rd_valid_i = 1'b1;
          rd_data_i  = mem_word(rd_addr_o);
          if (nlog < 8) addr_log[nlog] = rd_addr_o;
          nlog++;
          wait_cnt = (lat_max == 0) ? 0 : int'($urandom_range(lat_max, 0));
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic do_walk(input logic [31:0] b, input logic [31:0] va,
                         input logic [4:0] sh, input bit disturb);
    logic [31:0] d, ea, ex_even, ex_odd;
    int cyc;
    bit zero;
    zero = (b == 32'd0);
    @(negedge clk);
    nlog = 0;
    dir_base_i = b; vaddr_i = va; soft_shift_i = sh; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      soft_shift_i = ~sh;
      vaddr_i = $urandom;
      dir_base_i = $urandom;
    end
    chk(busy_o == 1'b1, "R7 busy after start", 32'(busy_o), 32'd1);
    if (zero) begin
      chk(done_o == 1'b1, "R1 done one cycle after start", 32'(done_o), 32'd1);
      chk(rd_req_o == 1'b0, "R1 no request", 32'(rd_req_o), 32'd0);
    end
    cyc = 0;
    while (!done_o && cyc < 500) begin
      start_i = (disturb && cyc == 2);
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R8 walk reached done", 32'(done_o), 32'd1);
    if (zero) begin
      chk(nomatch_o == 1'b1, "R1 nomatch", 32'(nomatch_o), 32'd1);
      chk(nlog == 0, "R1 read count", 32'(nlog), 32'd0);
      chk(entry_even_o == 0 && entry_odd_o == 0, "R1 entries zero", entry_even_o | entry_odd_o, 32'd0);
      ex_even = 0; ex_odd = 0;
    end else begin
      d = mem_word(exp_dir(b, va));
      ea = exp_pair(d, va);
      ex_even = mem_word(ea) >> sh;
      ex_odd  = mem_word(ea + 32'd4) >> sh;
      chk(nomatch_o == 1'b0, "R8 nomatch low", 32'(nomatch_o), 32'd0);
      chk(nlog == 3, "R4 read count", 32'(nlog), 32'd3);
      chk(addr_log[0] == exp_dir(b, va), "R2 directory address", addr_log[0], exp_dir(b, va));
      chk(addr_log[1] == ea, "R3 even address", addr_log[1], ea);
      chk(addr_log[2] == ea + 32'd4, "R4 odd address", addr_log[2], ea + 32'd4);
      chk(entry_even_o == ex_even, "R5 even entry", entry_even_o, ex_even);
      chk(entry_odd_o == ex_odd, "R5 odd entry", entry_odd_o, ex_odd);
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done pulse width", 32'(done_o), 32'd0);
    chk(busy_o == 1'b0 && rd_req_o == 1'b0, "R7 idle after done", 32'({busy_o, rd_req_o}), 32'd0);
    chk(entry_even_o == ex_even && entry_odd_o == ex_odd, "R8 entries held", entry_even_o, ex_even);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start_i = 1'b0; dir_base_i = '0; vaddr_i = '0; soft_shift_i = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(busy_o == 0 && done_o == 0 && nomatch_o == 0 && rd_req_o == 0, "R9 reset controls",
        32'({busy_o, done_o, nomatch_o, rd_req_o}), 32'd0);
    chk(entry_even_o == 0 && entry_odd_o == 0, "R9 reset entries", entry_even_o | entry_odd_o, 32'd0);

    // directed corners
    lat_max = 0;
    do_walk(32'd0, 32'h1234_5678, 5'd3, 1'b0);              // R1
    do_walk(32'h8000_1000, 32'h0000_0000, 5'd0, 1'b0);      // R2 low indices
    do_walk(32'hFFFF_FFFC, 32'hFFFF_FFFF, 5'd31, 1'b0);     // R2 R5 max values
    do_walk(32'hA000_0000, 32'h003F_E000, 5'd6, 1'b0);      // R3 max table index

    // R6: stray strobe while idle is ignored
    @(negedge clk);
    stray = 1'b1;
    repeat (3) @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && rd_req_o == 0, "R6 stray strobe ignored", 32'({busy_o, rd_req_o}), 32'd0);
    chk(nlog == 3, "R6 no read logged by stray", 32'(nlog), 32'd3);

    // R6 R7 long latency with disturbing inputs
    lat_max = 6;
    do_walk(32'h8123_4560, 32'hC0DE_3000, 5'd8, 1'b1);
    do_walk(32'd0, 32'hFFFF_0000, 5'd12, 1'b1);

    // random walks
    for (int i = 0; i < 40; i++) begin
      logic [31:0] b;
      lat_max = int'($urandom_range(4, 0));
      b = ($urandom_range(7, 0) == 0) ? 32'd0 : $urandom;
      do_walk(b, $urandom, 5'($urandom_range(31, 0)), 1'($urandom_range(1, 0)));
    end
    summary();
  end
endmodule